// File: doc/BRIEF.md
# Per-Thread Pause Counter Array

This block gives each hardware thread of a multithreaded core a way to stall itself for a chosen number of clock cycles. Software writes a 64-bit cycle count for one thread, picked by a thread index on a shared write port. That thread's block output then stays high for about that many cycles. The issue logic uses the block output to hold back instructions from the thread.

Each thread has its own down-counter and its own 3-bit prescaler, so each counter steps once every eight clocks. The written value is shifted right by three bits before it is loaded. The low three bits are therefore dropped, and the pause lasts eight cycles per remaining count. A write below eight still stalls the thread for exactly one cycle. A disrupting trap for a thread ends its pause at once.

Top module: `pause_ctr_array`

## Requirements
- R1: While reset is asserted, and after it is released with no write, every bit of `block_o` is 0.
- R2: A write of value V ≥ 8 to thread T raises `block_o[T]` in the cycle after the write. The bit stays high for exactly 8·(V>>3) cycles and then falls.
- R3: Bits [2:0] of the written value have no effect. For example, 15 gives the same pause as 8, and 47 gives the same pause as 40.
- R4: A write of a value from 0 to 7 raises `block_o[T]` for exactly one cycle.
- R5: A write to a thread that is already paused replaces its remaining count with the new shifted value. The eight-cycle prescaler restarts from zero at that write.
- R6: A high `trap_i[T]` at a clock edge makes `block_o[T]` low from the next cycle on and clears the pending count. A trap wins over a write to the same thread in the same cycle.
- R7: A trap on a thread that is not paused leaves its `block_o` bit low.
- R8: Threads are independent. A write changes only the thread named by `wr_tid_i`, and a trap changes only its own thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the pause value |
| wr_tid_i | input | TID_W | Index of the thread being written |
| wr_data_i | input | DATA_W | Requested pause length in cycles |
| trap_i | input | NUM_THREADS | Per-thread disrupting trap; cancels that thread's pause |
| block_o | output | NUM_THREADS | Per-thread stall request to the issue logic |

## Verification
The bench builds the array with NUM_THREADS = 4 and DATA_W = 64. Four threads are enough to keep pauses running in several threads at once while a write or trap hits only one of them. The full 64-bit width lets the bench load an all-ones value and check that the top of the shifted range loads and is later cancelled by a trap. Small values near multiples of eight exercise the one-cycle floor and the dropped low bits against exact cycle counts.

// File: rtl/pause_pkg.sv
package pause_pkg;
    // Counter steps once every 2**PRESCALE_LOG2 clocks.
    localparam int unsigned PRESCALE_LOG2 = 3;
endpackage

// File: rtl/pause_wr_decode.sv
module pause_wr_decode #(
    parameter int unsigned NUM_THREADS = 8,
    parameter int unsigned TID_W       = 3
) (
    input  logic                   wr_en_i,
    input  logic [TID_W-1:0]       wr_tid_i,
    output logic [NUM_THREADS-1:0] load_o
);
    always_comb begin
        for (int i = 0; i < NUM_THREADS; i++) begin
            load_o[i] = wr_en_i && (wr_tid_i == TID_W'(i));
        end
    end

    // R8: a write reaches at most one thread
    always_comb begin
        a_r8_single_target: assert ($onehot0(load_o))
            else $error("write decoded to several threads");
    end
endmodule

// File: rtl/pause_thread.sv
module pause_thread
    import pause_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              trap_i,
    output logic              blk_o
);
    localparam int unsigned PRE_W = PRESCALE_LOG2;
    localparam int unsigned CNT_W = DATA_W - PRE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
        logic             blk;
    } th_state_t;

    th_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.blk) begin
            if (st_q.cnt == '0) begin
                st_d.blk = 1'b0;
            end else if (st_q.pre == '1) begin
                st_d.pre = '0;
                st_d.cnt = st_q.cnt - CNT_W'(1);
                if (st_q.cnt == CNT_W'(1)) st_d.blk = 1'b0;
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
        if (load_i) begin
            st_d.cnt = wr_data_i[DATA_W-1:PRE_W];
            st_d.pre = '0;
            st_d.blk = 1'b1;
        end
        if (trap_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blk_o = st_q.blk;

    a_r2_block_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !trap_i) |=> blk_o)
        else $error("block not raised after write");

    a_r6_trap_releases: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i |=> (!blk_o && st_q.cnt == '0))
        else $error("trap did not end the pause");

    a_r2_holds_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_o && !trap_i && st_q.cnt > CNT_W'(1)) |=> blk_o)
        else $error("pause ended early");

    a_r5_no_count_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !trap_i) |=> (st_q.cnt <= $past(st_q.cnt)))
        else $error("count grew without a write");
endmodule

// File: rtl/pause_ctr_array.sv
module pause_ctr_array #(
    parameter int unsigned NUM_THREADS = 8,
    parameter int unsigned DATA_W      = 64,
    localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [TID_W-1:0]       wr_tid_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    input  logic [NUM_THREADS-1:0] trap_i,
    output logic [NUM_THREADS-1:0] block_o
);
    logic [NUM_THREADS-1:0] load;

    pause_wr_decode #(
        .NUM_THREADS(NUM_THREADS),
        .TID_W      (TID_W)
    ) u_dec (
        .wr_en_i (wr_en_i),
        .wr_tid_i(wr_tid_i),
        .load_o  (load)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        pause_thread #(
            .DATA_W(DATA_W)
        ) u_thr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load[t]),
            .wr_data_i(wr_data_i),
            .trap_i   (trap_i[t]),
            .blk_o    (block_o[t])
        );
    end

    a_r8_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && trap_i == '0 && block_o == '0) |=> (block_o == '0))
        else $error("block raised with no write");
endmodule

// File: tb/pause_ctr_array_tb.sv
`timescale 1ns/1ps
module pause_ctr_array_tb;
    localparam int NT = 4;
    localparam int DW = 64;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [TW-1:0] wr_tid = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NT-1:0] trap = '0;
    logic [NT-1:0] block;

    int     n_cmp = 0;
    int     n_bad = 0;
    int     cycles = 0;
    string  cur_req = "R1";
    logic [DW-1:0] rem [NT];

    always #2.5 clk = ~clk;

    pause_ctr_array #(.NUM_THREADS(NT), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_tid_i(wr_tid),
        .wr_data_i(wr_data), .trap_i(trap), .block_o(block)
    );

    // Behavioural model: remaining stall cycles per thread.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) rem[t] = '0;
        end else begin
            for (int t = 0; t < NT; t++) begin
                if (trap[t])                      rem[t] = '0;
                else if (wr_en && wr_tid == TW'(t))
                    rem[t] = (wr_data < 8) ? DW'(1) : (wr_data & ~DW'(7));
                else if (rem[t] != '0)            rem[t] = rem[t] - 1;
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        for (int t = 0; t < NT; t++) begin
            logic exp_b;
            exp_b = rst_n ? (rem[t] != '0) : 1'b0;
            n_cmp++;
            if (block[t] !== exp_b) begin
                n_bad++;
                $display("FAIL %s thread %0d cycle %0d: block=%b expected %b",
                         cur_req, t, cycles, block[t], exp_b);
            end
        end
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, got %0d cycles expected < 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int tid, input logic [DW-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_tid = TW'(tid); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic trp(input logic [NT-1:0] m);
        @(negedge clk);
        trap = m;
        @(negedge clk);
        trap = '0;
    endtask

    initial begin
        cur_req = "R1";                       // reset state
        idle(5);
        rst_n = 1'b1;
        idle(4);

        cur_req = "R2";                       // basic pause lengths
        wr(0, 40);  idle(50);
        wr(1, 24);  idle(30);

        cur_req = "R3";                       // low bits dropped
        wr(2, 15);  idle(12);
        wr(2, 47);  idle(50);

        cur_req = "R4";                       // one-cycle floor
        wr(3, 0);   idle(3);
        wr(3, 7);   idle(3);

        cur_req = "R5";                       // rewrite during pause
        wr(0, 80);  idle(13);
        wr(0, 16);  idle(30);
        wr(1, 16);  idle(5);
        wr(1, 16);  idle(25);

        cur_req = "R6";                       // trap cancels
        wr(1, 800); idle(20);
        trp(4'b0010); idle(5);
        wr(2, 40);
        @(negedge clk);
        wr_en = 1'b1; wr_tid = 2'd2; wr_data = 200; trap = 4'b0100;
        @(negedge clk);
        wr_en = 1'b0; trap = '0;
        idle(60);

        cur_req = "R7";                       // trap on idle thread
        trp(4'b1000); idle(4);

        cur_req = "R8";                       // independence
        wr(0, 64); wr(1, 32); wr(2, 8);
        idle(3);
        trp(4'b0001);
        idle(80);

        cur_req = "R2";                       // widest value, then cancel
        wr(3, {DW{1'b1}}); idle(20);
        trp(4'b1000); idle(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule